// File: doc/BRIEF.md
# Indexed Interrupt Mask and Force Register Block

This block keeps a 64-entry interrupt mask and a 64-entry force vector for an interrupt controller. Software changes one mask or force bit by writing that bit's index to a dedicated write-only command offset. No read-modify-write sequence is needed, so an interrupt handler can mask or unmask its own source with a single byte store. There are three commands: set a mask bit, clear a mask bit, and set a force bit. A flag in each mask command applies the operation to every mask bit at once.

Only the lower 44 indices are implemented. Commands that name an index from 44 to 63 do nothing. The mask and force vectors can also be read and written directly, one byte at a time. Any read of a command offset ends with an error response.

The block drives the mask and force vectors out as ports. It also produces a registered pending vector: raw requests, plus forced requests, with masked sources removed.

Top module: `irq_mask_force_regs`

## Requirements
- R1: A write to offset 0x1C with bit 7 clear sets mask bit `wdata[5:0]`, which disables that source. Bit 6 of the byte has no effect.
- R2: A write to offset 0x1D with bit 7 clear clears mask bit `wdata[5:0]`, which enables that source. Bit 6 of the byte has no effect.
- R3: A write to 0x1C with bit 7 set sets all 44 implemented mask bits. A write to 0x1D with bit 7 set clears all of them. In both cases the index field is ignored.
- R4: A write to offset 0x1E sets force bit `wdata[5:0]`. Bits 7 and 6 of the byte have no effect.
- R5: For any of the three commands, an index from 44 to 63 leaves the mask and force vectors unchanged. Mask and force bits 63..44 always read as 0.
- R6: A read of 0x1C, 0x1D or 0x1E returns `bus_err` with read data 0, and it changes no state.
- R7: After reset, mask bits 43..0 are 1, the force vector is 0 and the pending vector is 0.
- R8: Mask byte k (bits 8k+7..8k) is read and written at offset k, for k from 0 to 7. Force byte k is read and written at offset 8+k. Writes to bits 63..44 are dropped. A force bit is cleared only by such a direct write.
- R9: `pend_o` equals `(irq_req | force) & ~mask`, with bits 63..44 at 0. It is registered, so it follows a change of its inputs one clock later.
- R10: Each cycle with `bus_sel` high is answered one clock later by exactly one of `bus_ack` and `bus_err`. Reads of unmapped offsets return 0 with `bus_ack`. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte offset in the register window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | Normal completion, one cycle after `bus_sel` |
| bus_err | output | 1 | Error completion, one cycle after `bus_sel` |
| irq_req | input | 64 | Raw level interrupt requests |
| mask_o | output | 64 | Current mask vector |
| force_o | output | 64 | Current force vector |
| pend_o | output | 64 | Registered masked pending vector |

## Verification
The bench builds the block with its default parameters: 64 vector bits, 44 implemented, on a 5-bit byte window. With these values the 43/44 boundary and the top index 63 can be reached from both the command path and the direct byte path. Every byte of both vectors, including the partly reserved byte 5, is in range of random direct writes. Random command bytes carry random bits 6 and 7, so the all-bits flag and the ignored bit are exercised against both in-range and reserved indices.

// File: rtl/irqmf_pkg.sv
package irqmf_pkg;
  localparam int OFS_SET_MASK  = 'h1C;
  localparam int OFS_CLR_MASK  = 'h1D;
  localparam int OFS_SET_FORCE = 'h1E;
  localparam int ALL_BIT       = 7;
endpackage

// File: rtl/irqmf_decode.sv
module irqmf_decode
  import irqmf_pkg::*;
#(
  parameter int NUM_SRC   = 64,
  parameter int NUM_VALID = 44,
  parameter int ADDR_W    = 5,
  localparam int NBYTES   = NUM_SRC / 8,
  localparam int IDX_W    = $clog2(NUM_SRC)
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [NUM_SRC-1:0] set_m,
  output logic [NUM_SRC-1:0] clr_m,
  output logic [NUM_SRC-1:0] set_f,
  output logic [NBYTES-1:0]  byte_wm,
  output logic [NBYTES-1:0]  byte_wf,
  output logic               is_cmd
);
  logic             hit_sm, hit_cm, hit_sf, all_flag;
  logic [IDX_W-1:0] idx;

  assign hit_sm   = addr == ADDR_W'(OFS_SET_MASK);
  assign hit_cm   = addr == ADDR_W'(OFS_CLR_MASK);
  assign hit_sf   = addr == ADDR_W'(OFS_SET_FORCE);
  assign is_cmd   = hit_sm | hit_cm | hit_sf;
  assign all_flag = wdata[ALL_BIT];
  assign idx      = wdata[IDX_W-1:0];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    if (i < NUM_VALID) begin : g_valid
      logic pick;
      assign pick     = idx == IDX_W'(i);
      assign set_m[i] = sel & wr & hit_sm & (all_flag | pick);
      assign clr_m[i] = sel & wr & hit_cm & (all_flag | pick);
      assign set_f[i] = sel & wr & hit_sf & pick;
    end else begin : g_resv
      assign set_m[i] = 1'b0;
      assign clr_m[i] = 1'b0;
      assign set_f[i] = 1'b0;
    end
  end

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    assign byte_wm[k] = sel & wr & (addr == ADDR_W'(k));
    assign byte_wf[k] = sel & wr & (addr == ADDR_W'(NBYTES + k));
  end
endmodule

// File: rtl/irqmf_vec.sv
module irqmf_vec #(
  parameter int NUM_SRC   = 64,
  parameter int NUM_VALID = 44,
  localparam int NBYTES   = NUM_SRC / 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_m,
  input  logic [NUM_SRC-1:0] clr_m,
  input  logic [NUM_SRC-1:0] set_f,
  input  logic [NBYTES-1:0]  byte_wm,
  input  logic [NBYTES-1:0]  byte_wf,
  input  logic [7:0]         wdata,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] force_q
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    if (i < NUM_VALID) begin : g_valid
      always_ff @(posedge clk) begin
        if (rst) begin
          mask_q[i]  <= 1'b1;
          force_q[i] <= 1'b0;
        end else begin
          if (byte_wm[i/8])  mask_q[i] <= wdata[i%8];
          else if (clr_m[i]) mask_q[i] <= 1'b0;
          else if (set_m[i]) mask_q[i] <= 1'b1;
          if (byte_wf[i/8])  force_q[i] <= wdata[i%8];
          else if (set_f[i]) force_q[i] <= 1'b1;
        end
      end
    end else begin : g_resv
      assign mask_q[i]  = 1'b0;
      assign force_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irqmf_pend.sv
module irqmf_pend #(
  parameter int NUM_SRC   = 64,
  parameter int NUM_VALID = 44
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] mask_q,
  input  logic [NUM_SRC-1:0] force_q,
  output logic [NUM_SRC-1:0] pend_q
);
  localparam logic [NUM_SRC-1:0] VALID =
    (NUM_VALID >= NUM_SRC) ? '1 : (({{(NUM_SRC-1){1'b0}}, 1'b1} << NUM_VALID) - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (req | force_q) & ~mask_q & VALID;
  end
endmodule

// File: rtl/irq_mask_force_regs.sv
module irq_mask_force_regs
  import irqmf_pkg::*;
#(
  parameter int NUM_SRC   = 64,
  parameter int NUM_VALID = 44,
  parameter int ADDR_W    = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  output logic               bus_ack,
  output logic               bus_err,
  input  logic [NUM_SRC-1:0] irq_req,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] force_o,
  output logic [NUM_SRC-1:0] pend_o
);
  localparam int NBYTES = NUM_SRC / 8;
  localparam int IDX_W  = $clog2(NUM_SRC);
  localparam logic [NUM_SRC-1:0] VALID =
    (NUM_VALID >= NUM_SRC) ? '1 : (({{(NUM_SRC-1){1'b0}}, 1'b1} << NUM_VALID) - 1'b1);

  logic [NUM_SRC-1:0] set_m, clr_m, set_f, mask_q, force_q;
  logic [NBYTES-1:0]  byte_wm, byte_wf;
  logic               is_cmd;
  logic [7:0]         rd_mux;
  logic               ack_q, err_q;
  logic [7:0]         rdata_q;

  irqmf_decode #(.NUM_SRC(NUM_SRC), .NUM_VALID(NUM_VALID), .ADDR_W(ADDR_W)) u_dec (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .set_m(set_m), .clr_m(clr_m), .set_f(set_f),
    .byte_wm(byte_wm), .byte_wf(byte_wf), .is_cmd(is_cmd));

  irqmf_vec #(.NUM_SRC(NUM_SRC), .NUM_VALID(NUM_VALID)) u_vec (
    .clk(clk), .rst(rst), .set_m(set_m), .clr_m(clr_m), .set_f(set_f),
    .byte_wm(byte_wm), .byte_wf(byte_wf), .wdata(bus_wdata),
    .mask_q(mask_q), .force_q(force_q));

  irqmf_pend #(.NUM_SRC(NUM_SRC), .NUM_VALID(NUM_VALID)) u_pend (
    .clk(clk), .rst(rst), .req(irq_req), .mask_q(mask_q),
    .force_q(force_q), .pend_q(pend_o));

  always_comb begin
    rd_mux = 8'h00;
    for (int k = 0; k < NBYTES; k++) begin
      if (bus_addr == ADDR_W'(k))          rd_mux = mask_q[8*k +: 8];
      if (bus_addr == ADDR_W'(NBYTES + k)) rd_mux = force_q[8*k +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= 8'h00;
    end else begin
      ack_q   <= bus_sel & (bus_wr | ~is_cmd);
      err_q   <= bus_sel & ~bus_wr & is_cmd;
      rdata_q <= (bus_sel & ~bus_wr & ~is_cmd) ? rd_mux : 8'h00;
    end
  end

  assign bus_ack   = ack_q;
  assign bus_err   = err_q;
  assign bus_rdata = rdata_q;
  assign mask_o    = mask_q;
  assign force_o   = force_q;

  assert_setm_idx_R1: assert property (@(posedge clk) disable iff (rst)
    $past(bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_SET_MASK) && !bus_wdata[ALL_BIT]
          && bus_wdata[IDX_W-1:0] < IDX_W'(NUM_VALID))
    |-> mask_o[$past(bus_wdata[IDX_W-1:0])]);

  assert_clrm_idx_R2: assert property (@(posedge clk) disable iff (rst)
    $past(bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_CLR_MASK) && !bus_wdata[ALL_BIT]
          && bus_wdata[IDX_W-1:0] < IDX_W'(NUM_VALID))
    |-> !mask_o[$past(bus_wdata[IDX_W-1:0])]);

  assert_set_all_R3: assert property (@(posedge clk) disable iff (rst)
    $past(bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_SET_MASK) && bus_wdata[ALL_BIT])
    |-> mask_o == VALID);

  assert_clr_all_R3: assert property (@(posedge clk) disable iff (rst)
    $past(bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_CLR_MASK) && bus_wdata[ALL_BIT])
    |-> mask_o == '0);

  assert_force_idx_R4: assert property (@(posedge clk) disable iff (rst)
    $past(bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_SET_FORCE)
          && bus_wdata[IDX_W-1:0] < IDX_W'(NUM_VALID))
    |-> force_o[$past(bus_wdata[IDX_W-1:0])]);

  assert_resv_idx_R5: assert property (@(posedge clk) disable iff (rst)
    $past(bus_sel && bus_wr && is_cmd && !(bus_wdata[ALL_BIT] && bus_addr != ADDR_W'(OFS_SET_FORCE))
          && bus_wdata[IDX_W-1:0] >= IDX_W'(NUM_VALID))
    |-> $stable(mask_o) && $stable(force_o));

  assert_err_cause_R6: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_sel && !bus_wr && is_cmd));

  assert_err_stable_R6: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $stable(mask_o) && $stable(force_o) && bus_rdata == 8'h00);

  assert_resp_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_ack, bus_err}) && ((bus_ack || bus_err) == $past(bus_sel)));
endmodule

// File: tb/test_irq_mask_force_regs.sv
module test_irq_mask_force_regs;
  localparam int NS = 64;
  localparam int NV = 44;
  localparam logic [63:0] VALID = (64'd1 << NV) - 64'd1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_ack, bus_err;
  logic [63:0] irq_req = '0;
  logic [63:0] mask_o, force_o, pend_o;

  int checks = 0, fails = 0;
  logic [63:0] m_mask, m_force;

  always #5 clk = ~clk;

  irq_mask_force_regs i_irq_mask_force_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err),
    .irq_req(irq_req), .mask_o(mask_o), .force_o(force_o), .pend_o(pend_o));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_pend();
    return (irq_req | m_force) & ~m_mask & VALID;
  endfunction

  function automatic bit is_cmd(input logic [4:0] a);
    return a == 5'h1C || a == 5'h1D || a == 5'h1E;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [4:0] a);
    if (is_cmd(a)) return 8'h00;
    if (a < 5'd8)  return m_mask[8*a +: 8];
    if (a < 5'd16) return m_force[8*(a-8) +: 8];
    return 8'h00;
  endfunction

  function automatic void model_write(input logic [4:0] a, input logic [7:0] d);
    int idx = int'(d[5:0]);
    if (a == 5'h1C) begin
      if (d[7]) m_mask = VALID; else if (idx < NV) m_mask[idx] = 1'b1;
    end else if (a == 5'h1D) begin
      if (d[7]) m_mask = '0; else if (idx < NV) m_mask[idx] = 1'b0;
    end else if (a == 5'h1E) begin
      if (idx < NV) m_force[idx] = 1'b1;
    end else if (a < 5'd8) begin
      m_mask[8*a +: 8] = d & VALID[8*a +: 8];
    end else if (a < 5'd16) begin
      m_force[8*(a-8) +: 8] = d & VALID[8*(a-8) +: 8];
    end
  endfunction

  // One access, then checks of the response, the vectors and the pending output.
  task automatic access(input string req, input logic wr, input logic [4:0] a, input logic [7:0] d);
    logic [7:0] erd;
    bit eerr;
    erd  = wr ? 8'h00 : exp_rd(a);
    eerr = !wr && is_cmd(a);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0;
    if (wr) model_write(a, d);
    check({req, " R10 resp"}, {62'd0, bus_ack, bus_err}, {62'd0, !eerr, eerr});
    if (eerr) check({req, " R6 err"}, {63'd0, bus_err}, 64'd1);
    check({req, " rdata"}, {56'd0, bus_rdata}, {56'd0, erd});
    check({req, " mask"}, mask_o, m_mask);
    check({req, " force"}, force_o, m_force);
    @(negedge clk);
    check({req, " R9 pend"}, pend_o, exp_pend());
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    m_mask = VALID; m_force = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R7 reset mask", mask_o, VALID);
    check("R7 reset force", force_o, 64'd0);
    check("R7 reset pend", pend_o, 64'd0);

    irq_req = 64'hFFFF_FFFF_FFFF_FFFF;
    access("R2 clr 43", 1'b1, 5'h1D, 8'd43);
    access("R2 clr 0 bit6", 1'b1, 5'h1D, 8'h40);
    access("R5 clr 44", 1'b1, 5'h1D, 8'd44);
    access("R3 clr all", 1'b1, 5'h1D, 8'h80 | 8'd50);
    access("R1 set 43 bit6", 1'b1, 5'h1C, 8'h40 | 8'd43);
    access("R5 set 63", 1'b1, 5'h1C, 8'd63);
    access("R3 set all bit6", 1'b1, 5'h1C, 8'hC0 | 8'd63);
    access("R8 mask byte5", 1'b1, 5'd5, 8'hFF);
    access("R8 mask byte5 wr", 1'b1, 5'd5, 8'h00);
    irq_req = '0;
    access("R4 force 7 flags", 1'b1, 5'h1E, 8'hC7);
    access("R5 force 44", 1'b1, 5'h1E, 8'd44);
    access("R8 read force0", 1'b0, 5'd8, 8'h00);
    access("R6 read setm", 1'b0, 5'h1C, 8'h00);
    access("R6 read clrm", 1'b0, 5'h1D, 8'h00);
    access("R6 read setf", 1'b0, 5'h1E, 8'h00);
    access("R8 clear force0", 1'b1, 5'd8, 8'h00);
    access("R10 unmapped wr", 1'b1, 5'h1F, 8'hFF);
    access("R10 unmapped rd", 1'b0, 5'h14, 8'h00);

    for (int n = 0; n < 3000; n++) begin
      int kind = int'($urandom_range(0, 9));
      logic [7:0] d = 8'($urandom);
      if (kind < 3 && $urandom_range(0, 7) != 0) d[7] = 1'b0;
      if ($urandom_range(0, 3) == 0) irq_req = {$urandom, $urandom};
      case (kind)
        0: access("R1 rnd setm", 1'b1, 5'h1C, d);
        1: access("R2 rnd clrm", 1'b1, 5'h1D, d);
        2: access("R4 rnd setf", 1'b1, 5'h1E, d);
        3: access("R6 rnd cmd rd", 1'b0, 5'(8'h1C + 8'($urandom_range(0, 2))), d);
        4: access("R8 rnd mask wr", 1'b1, 5'($urandom_range(0, 7)), d);
        5: access("R8 rnd force wr", 1'b1, 5'($urandom_range(8, 15)), d);
        6: access("R8 rnd rd", 1'b0, 5'($urandom_range(0, 15)), d);
        7: access("R10 rnd any", $urandom_range(0, 1) == 1, 5'($urandom), d);
        default: access("R5 rnd resv", 1'b1, 5'(8'h1C + 8'($urandom_range(0, 2))),
                        8'($urandom_range(44, 63)) | (d & 8'h40));
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule